// File: doc/BRIEF.md
# Program Address Trace Compressor

This block squeezes a live stream of instruction-fetch addresses into short packets for on-chip trace capture. It accepts one valid-qualified address per clock and runs it through three registered phases. The first phase keeps only the edges of each sequential run: the address that opens the run (the target) and the address that closes it (the branch). The second phase looks each kept address up in a small dictionary and replaces a hit with its slot index. The third phase takes the misses and emits only the low nibble-wide slices that moved since the previous miss.

A restart strobe starts a new, independent trace segment. In one cycle it wipes the filter history, the dictionary, the previous-miss register and everything in flight. Each segment therefore opens with a full-width address and can be decoded without any earlier data.

The filter is a three-state machine. `FS_EMPTY` means there is no history yet. `FS_SINGLE` means the last address opened a run. `FS_RUN` means the last address continued a run. Its transitions are:
- EMPTY to SINGLE on any address.
- SINGLE to RUN on a sequential address.
- SINGLE to SINGLE on a jump.
- RUN to RUN on a sequential address.
- RUN to SINGLE on a jump, which releases the branch.
- Any state to EMPTY on restart.

A run's target waits in a one-entry pending slot and leaves on the next cycle that has no branch to release. The slice coder has two states. `SL_FRESH` means no miss has been seen yet, so the next miss is sent in full. `SL_PRIMED` means later misses are delta coded. It moves from FRESH to PRIMED on the first miss, and back to FRESH on restart.

Top module: `ptc_trace_compressor`

## Requirements
- R1: After reset, and while no address is offered, `out_valid` stays low.
- R2: An address counts as sequential when it equals the previous valid address plus 4, modulo 2^32. Sequential addresses inside a run produce no packet. The first address of every run produces a packet.
- R3: When a run of two or more addresses is ended by a non-sequential address, the run's last address produces a packet. That packet comes after the run's target packet and before the next run's target packet. A run of one address produces exactly one packet.
- R4: A kept address that is already in the dictionary produces an index packet with `out_kind`=1, `out_len`=0 and `out_payload` equal to the slot number, zero-extended.
- R5: A kept address that misses is written to the slot named by a round-robin pointer. The pointer starts at slot 0 and advances on every miss, wrapping after slot 7. The ninth distinct miss therefore evicts the first one.
- R6: The first miss after reset or restart produces a sliced packet with `out_kind`=0, `out_len`=8 and the full address as payload.
- R7: Each later miss produces a sliced packet with `out_kind`=0. Slices are 4 bits wide, and slice s is address bits [4s+3:4s]. `out_len` is one plus the index of the highest slice that differs from the previous miss, or 1 when no slice differs. The payload holds the address's low `out_len` slices, with the bits above them zero.
- R8: A restart pulse discards the held run state, the pending target, the dictionary contents and the packets in flight, and `out_valid` is low in the cycle after it. An address seen before the restart then misses and is coded in full.
- R9: Addresses offered on every cycle, including an unbroken chain of jumps, are all accepted. Every packet they produce comes out in order, three cycles after the filter decides to emit it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart | input | 1 | Begin a new independent trace segment; the address in the same cycle is dropped |
| in_valid | input | 1 | An address is offered this cycle |
| in_addr | input | 32 | Instruction-fetch address |
| out_valid | output | 1 | A packet is present this cycle |
| out_kind | output | 1 | 0 = sliced address, 1 = dictionary index |
| out_len | output | 4 | Slice count of a sliced packet; 0 for an index packet |
| out_payload | output | 32 | Low slices of the address, or the dictionary slot number |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 4-bit slices and 8 dictionary slots. With eight slices, every delta length from one slice up to the full address appears in ordinary address patterns. With eight slots, a chain of nine jumps is enough to wrap the round-robin pointer and show an eviction. The tests cover loop bodies that return to the dictionary, unbroken chains of jumps, runs interrupted by idle cycles, a run that crosses the top of the address space, and a restart that makes previously known addresses miss.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    typedef enum logic [1:0] {
        FS_EMPTY  = 2'd0,
        FS_SINGLE = 2'd1,
        FS_RUN    = 2'd2
    } filt_state_e;

    typedef enum logic {
        SL_FRESH  = 1'b0,
        SL_PRIMED = 1'b1
    } slice_state_e;

    localparam logic KIND_SLICE = 1'b0;
    localparam logic KIND_INDEX = 1'b1;

endpackage

// File: rtl/ptc_filter.sv
module ptc_filter
    import ptc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STRIDE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              f_valid,
    output logic [ADDR_W-1:0] f_addr
);

    filt_state_e       state_q, state_d;
    logic [ADDR_W-1:0] last_q;
    logic [ADDR_W-1:0] pend_q;
    logic              pend_v_q;

    logic              seq;
    logic              emit_v;
    logic [ADDR_W-1:0] emit_a;
    logic              emit_pend;
    logic              load_pend;

    assign seq = (state_q != FS_EMPTY) && (in_addr == last_q + ADDR_W'(STRIDE));

    // next state and emission choice
    always_comb begin
        state_d   = state_q;
        emit_v    = pend_v_q;
        emit_a    = pend_q;
        emit_pend = pend_v_q;
        load_pend = 1'b0;
        if (in_valid) begin
            unique case (state_q)
                FS_EMPTY: begin
                    state_d   = FS_SINGLE;
                    load_pend = 1'b1;
                end
                FS_SINGLE: begin
                    if (seq) begin
                        state_d = FS_RUN;
                    end else begin
                        state_d   = FS_SINGLE;
                        load_pend = 1'b1;
                    end
                end
                FS_RUN: begin
                    if (seq) begin
                        state_d = FS_RUN;
                    end else begin
                        state_d   = FS_SINGLE;
                        emit_v    = 1'b1;
                        emit_a    = last_q;
                        emit_pend = 1'b0;
                        load_pend = 1'b1;
                    end
                end
                default: state_d = FS_EMPTY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= FS_EMPTY;
            last_q   <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
        end else if (restart) begin
            state_q  <= FS_EMPTY;
            last_q   <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (in_valid) begin
                last_q <= in_addr;
            end
            if (load_pend) begin
                pend_q   <= in_addr;
                pend_v_q <= 1'b1;
            end else if (emit_pend) begin
                pend_v_q <= 1'b0;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_valid <= 1'b0;
            f_addr  <= '0;
        end else if (restart) begin
            f_valid <= 1'b0;
            f_addr  <= '0;
        end else begin
            f_valid <= emit_v;
            f_addr  <= emit_a;
        end
    end

endmodule

// File: rtl/ptc_dict.sv
module ptc_dict #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              f_valid,
    input  logic [ADDR_W-1:0] f_addr,
    output logic              d_valid,
    output logic              d_hit,
    output logic [IDX_W-1:0]  d_idx,
    output logic [ADDR_W-1:0] d_addr
);

    logic [ADDR_W-1:0] ent_a [DEPTH];
    logic [DEPTH-1:0]  ent_v;
    logic [IDX_W-1:0]  ptr_q;
    logic [DEPTH-1:0]  match;
    logic [IDX_W-1:0]  hit_idx;
    logic              hit;
    logic              insert;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = ent_v[i] && (ent_a[i] == f_addr);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end

    assign hit    = |match;
    assign insert = f_valid && !hit;

    always_ff @(posedge clk) begin
        if (insert) begin
            ent_a[ptr_q] <= f_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_v <= '0;
            ptr_q <= '0;
        end else if (restart) begin
            ent_v <= '0;
            ptr_q <= '0;
        end else if (insert) begin
            ent_v[ptr_q] <= 1'b1;
            ptr_q        <= (ptr_q == IDX_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_valid <= 1'b0;
            d_hit   <= 1'b0;
            d_idx   <= '0;
            d_addr  <= '0;
        end else if (restart) begin
            d_valid <= 1'b0;
            d_hit   <= 1'b0;
            d_idx   <= '0;
            d_addr  <= '0;
        end else begin
            d_valid <= f_valid;
            d_hit   <= hit;
            d_idx   <= hit_idx;
            d_addr  <= f_addr;
        end
    end

endmodule

// File: rtl/ptc_slicer.sv
module ptc_slicer
    import ptc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SLICE_W = 4,
    parameter int IDX_W   = 3,
    localparam int NSLICE = ADDR_W / SLICE_W,
    localparam int LEN_W  = $clog2(NSLICE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              d_valid,
    input  logic              d_hit,
    input  logic [IDX_W-1:0]  d_idx,
    input  logic [ADDR_W-1:0] d_addr,
    output logic              out_valid,
    output logic              out_kind,
    output logic [LEN_W-1:0]  out_len,
    output logic [ADDR_W-1:0] out_payload
);

    slice_state_e      st_q;
    logic [ADDR_W-1:0] prev_q;
    logic [NSLICE-1:0] diff;
    logic [LEN_W-1:0]  top_cnt;
    logic [LEN_W-1:0]  cnt;
    logic [ADDR_W-1:0] keep;
    logic              miss;

    assign miss = d_valid && !d_hit;

    for (genvar s = 0; s < NSLICE; s++) begin : g_diff
        assign diff[s] = d_addr[s*SLICE_W +: SLICE_W] != prev_q[s*SLICE_W +: SLICE_W];
    end

    always_comb begin
        top_cnt = '0;
        for (int s = 0; s < NSLICE; s++) begin
            if (diff[s]) begin
                top_cnt = LEN_W'(s + 1);
            end
        end
    end

    always_comb begin
        unique case (st_q)
            SL_FRESH:  cnt = LEN_W'(NSLICE);
            SL_PRIMED: cnt = (top_cnt == '0) ? LEN_W'(1) : top_cnt;
            default:   cnt = LEN_W'(NSLICE);
        endcase
    end

    always_comb begin
        keep = '0;
        for (int s = 0; s < NSLICE; s++) begin
            keep[s*SLICE_W +: SLICE_W] = (s < int'(cnt)) ? {SLICE_W{1'b1}} : {SLICE_W{1'b0}};
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= SL_FRESH;
            prev_q <= '0;
        end else if (restart) begin
            st_q   <= SL_FRESH;
            prev_q <= '0;
        end else if (miss) begin
            st_q   <= SL_PRIMED;
            prev_q <= d_addr;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_kind    <= KIND_SLICE;
            out_len     <= '0;
            out_payload <= '0;
        end else if (restart) begin
            out_valid   <= 1'b0;
            out_kind    <= KIND_SLICE;
            out_len     <= '0;
            out_payload <= '0;
        end else begin
            out_valid <= d_valid;
            if (d_hit) begin
                out_kind    <= KIND_INDEX;
                out_len     <= '0;
                out_payload <= ADDR_W'(d_idx);
            end else begin
                out_kind    <= KIND_SLICE;
                out_len     <= cnt;
                out_payload <= d_addr & keep;
            end
        end
    end

endmodule

// File: rtl/ptc_trace_compressor.sv
module ptc_trace_compressor #(
    parameter int ADDR_W     = 32,
    parameter int SLICE_W    = 4,
    parameter int DICT_DEPTH = 8,
    parameter int STRIDE     = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   restart,
    input  logic                                   in_valid,
    input  logic [ADDR_W-1:0]                      in_addr,
    output logic                                   out_valid,
    output logic                                   out_kind,
    output logic [$clog2(ADDR_W/SLICE_W+1)-1:0]    out_len,
    output logic [ADDR_W-1:0]                      out_payload
);

    localparam int IDX_W = (DICT_DEPTH > 1) ? $clog2(DICT_DEPTH) : 1;

    logic              f_valid;
    logic [ADDR_W-1:0] f_addr;
    logic              d_valid;
    logic              d_hit;
    logic [IDX_W-1:0]  d_idx;
    logic [ADDR_W-1:0] d_addr;

    ptc_filter #(
        .ADDR_W (ADDR_W),
        .STRIDE (STRIDE)
    ) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .in_valid (in_valid),
        .in_addr  (in_addr),
        .f_valid  (f_valid),
        .f_addr   (f_addr)
    );

    ptc_dict #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DICT_DEPTH)
    ) u_dict (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .f_valid (f_valid),
        .f_addr  (f_addr),
        .d_valid (d_valid),
        .d_hit   (d_hit),
        .d_idx   (d_idx),
        .d_addr  (d_addr)
    );

    ptc_slicer #(
        .ADDR_W  (ADDR_W),
        .SLICE_W (SLICE_W),
        .IDX_W   (IDX_W)
    ) u_slicer (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .d_valid     (d_valid),
        .d_hit       (d_hit),
        .d_idx       (d_idx),
        .d_addr      (d_addr),
        .out_valid   (out_valid),
        .out_kind    (out_kind),
        .out_len     (out_len),
        .out_payload (out_payload)
    );

endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
    parameter int ADDR_W     = 32,
    parameter int SLICE_W    = 4,
    parameter int DICT_DEPTH = 8,
    localparam int NSLICE    = ADDR_W / SLICE_W,
    localparam int LEN_W     = $clog2(NSLICE + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restart,
    input logic              out_valid,
    input logic              out_kind,
    input logic [LEN_W-1:0]  out_len,
    input logic [ADDR_W-1:0] out_payload
);

    logic primed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primed <= 1'b0;
        end else if (restart) begin
            primed <= 1'b0;
        end else if (out_valid && !out_kind) begin
            primed <= 1'b1;
        end
    end

    // R4
    idx_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind |-> (out_len == '0) && (out_payload < ADDR_W'(DICT_DEPTH)));

    // R7
    slice_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_kind |-> (out_len >= LEN_W'(1)) && (out_len <= LEN_W'(NSLICE)));

    // R7
    payload_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_kind && (out_len < LEN_W'(NSLICE))
        |-> ((out_payload >> (int'(out_len) * SLICE_W)) == '0));

    // R6
    first_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_kind && !primed |-> out_len == LEN_W'(NSLICE));

    // R8
    restart_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !out_valid);

endmodule

bind ptc_trace_compressor ptc_checker #(
    .ADDR_W     (ADDR_W),
    .SLICE_W    (SLICE_W),
    .DICT_DEPTH (DICT_DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (restart),
    .out_valid   (out_valid),
    .out_kind    (out_kind),
    .out_len     (out_len),
    .out_payload (out_payload)
);

// File: tb/ptc_trace_compressor_tb.sv
module ptc_trace_compressor_tb;

    localparam int AW = 32;
    localparam int SW = 4;
    localparam int NS = AW / SW;
    localparam int DD = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          restart = 1'b0;
    logic          in_valid = 1'b0;
    logic [AW-1:0] in_addr = '0;
    logic          out_valid;
    logic          out_kind;
    logic [3:0]    out_len;
    logic [AW-1:0] out_payload;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic [36:0] exp_q[$];
    string       tag_q[$];
    string       cur_tag = "R1";

    // reference state
    logic [AW-1:0] m_da [DD];
    bit            m_dv [DD];
    int            m_ptr;
    bit            m_fresh;
    logic [AW-1:0] m_prev;
    bit            m_has_last;
    logic [AW-1:0] m_last;
    int            m_run_len;

    always #10 clk = ~clk;

    ptc_trace_compressor u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .in_valid    (in_valid),
        .in_addr     (in_addr),
        .out_valid   (out_valid),
        .out_kind    (out_kind),
        .out_len     (out_len),
        .out_payload (out_payload)
    );

    task automatic model_clear();
        for (int i = 0; i < DD; i++) m_dv[i] = 1'b0;
        m_ptr      = 0;
        m_fresh    = 1'b1;
        m_prev     = '0;
        m_has_last = 1'b0;
        m_last     = '0;
        m_run_len  = 0;
    endtask

    task automatic code_addr(input logic [AW-1:0] a);
        int hi;
        int len;
        logic [AW-1:0] pay;
        hi = -1;
        for (int i = 0; i < DD; i++) if (m_dv[i] && m_da[i] == a) hi = i;
        if (hi >= 0) begin
            exp_q.push_back({1'b1, 4'd0, AW'(hi)});
        end else begin
            if (m_fresh) begin
                len = NS;
            end else begin
                len = 1;
                for (int s = NS - 1; s >= 0; s--) begin
                    if (((a >> (s * SW)) & 4'hF) != ((m_prev >> (s * SW)) & 4'hF)) begin
                        len = s + 1;
                        break;
                    end
                end
            end
            pay = (len == NS) ? a : (a & ((AW'(1) << (len * SW)) - AW'(1)));
            exp_q.push_back({1'b0, 4'(len), pay});
            m_da[m_ptr] = a;
            m_dv[m_ptr] = 1'b1;
            m_ptr       = (m_ptr + 1) % DD;
            m_prev      = a;
            m_fresh     = 1'b0;
        end
        tag_q.push_back(cur_tag);
    endtask

    task automatic send(input logic [AW-1:0] a);
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = a;
        if (m_has_last && a == m_last + 32'd4) begin
            m_run_len++;
        end else begin
            if (m_has_last && m_run_len >= 2) code_addr(m_last);
            code_addr(a);
            m_run_len = 1;
        end
        m_has_last = 1'b1;
        m_last     = a;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic do_restart();
        idle(6);
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        model_clear();
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            compared++;
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL unexpected packet: got kind=%0d len=%0d payload=%h expected none (R2)",
                         out_kind, out_len, out_payload);
            end else begin
                logic [36:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({out_kind, out_len, out_payload} !== e) begin
                    mismatched++;
                    $display("FAIL %s: got kind=%0d len=%0d payload=%h expected kind=%0d len=%0d payload=%h",
                             t, out_kind, out_len, out_payload, e[36], e[35:32], e[31:0]);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired (R9)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet after reset with no input
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            compared++;
            if (out_valid !== 1'b0) begin
                mismatched++;
                $display("FAIL R1: got out_valid=%0b expected 0", out_valid);
            end
        end

        // R2 R3 R6 R7: sequential run closed by a jump
        cur_tag = "R2 run filter";
        send(32'h0000_1000); send(32'h0000_1004); send(32'h0000_1008); send(32'h0000_100C);
        cur_tag = "R3 branch then target";
        send(32'h0000_2000); send(32'h0000_2004);
        // R4: loop back into known addresses
        cur_tag = "R4 dictionary hit";
        send(32'h0000_1000); send(32'h0000_1004); send(32'h0000_1008); send(32'h0000_100C);
        send(32'h0000_2000); send(32'h0000_2004);
        send(32'h0000_1000);
        idle(3);

        // R9: unbroken chain of single-address runs
        cur_tag = "R9 back-to-back jumps";
        for (int i = 0; i < 6; i++) send(32'h0000_3000 + 32'(i * 32'h110));
        cur_tag = "R7 slice delta";
        send(32'h0000_0120); send(32'h0000_0126); send(32'h0000_0166);
        send(32'h1234_5678); send(32'h1234_5679);
        idle(2);

        // R2: run with idle gaps inside
        cur_tag = "R2 gapped run";
        send(32'h0000_4000); idle(2); send(32'h0000_4004); idle(1); send(32'h0000_4008);
        send(32'h0000_5000);
        // R2: run crossing the top of the address space
        cur_tag = "R2 wrap run";
        send(32'hFFFF_FFF8); send(32'hFFFF_FFFC); send(32'h0000_0000); send(32'h0000_0004);
        send(32'h0000_6000);
        // R3: the same address twice
        cur_tag = "R3 repeat";
        send(32'h0000_7000); send(32'h0000_7000);
        idle(3);

        // R5: eviction after a full round of the pointer
        do_restart();
        cur_tag = "R5 round robin";
        for (int i = 0; i < 9; i++) send(32'h0001_0000 + 32'(i * 32'h40));
        send(32'h0001_0000);
        send(32'h0001_0040);
        send(32'h0001_0200);
        idle(3);

        // R8: restart with an open run, then a known address misses in full
        cur_tag = "R8 restart";
        send(32'h0000_1000); send(32'h0000_1004); send(32'h0000_1008);
        do_restart();
        cur_tag = "R8 after restart";
        send(32'h0000_1000); send(32'h0000_1000);
        send(32'h0000_8000); send(32'h0000_8004);
        send(32'h0000_1000);
        idle(8);

        // R9: nothing left outstanding
        compared++;
        if (exp_q.size() != 0) begin
            mismatched++;
            $display("FAIL R9: got %0d packets missing expected 0", exp_q.size());
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule